// File: doc/BRIEF.md
# Asynchronous SRAM/NOR Memory Controller

This block connects an on-chip request port to an external asynchronous memory, either SRAM or NOR flash. A requester presents an address, write data, a byte mask and a direction flag with a valid/ready handshake. The controller then runs one bus access with four phases. Two fixed bus-start cycles come first. Then come a setup phase, a strobe phase and a hold phase, whose lengths are taken from separate read and write timing inputs. During the access it drives chip select, output enable, write enable, active-low byte lanes, the address, and a data bus split into out, drive-enable and in pins.

The request side follows valid/ready rules. A request is taken on any rising edge where `req_valid` and `req_ready` are both high. The requester must hold its fields steady while `req_valid` is high and `req_ready` is low. `req_ready` goes high in idle and again in the last hold cycle, so a queued request starts at once without an idle gap. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse and the requester must take it. This is because an external access cannot be paused once it has begun. The data path can be 16 or 32 bits wide. An optional wait pin can lengthen the strobe phase, and an optional timeout limits how long that lengthening can last.

Top module: `asram_ctrl`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is high only when idle or in the final hold cycle. It is low in the cycle after an accept. Address, data, byte mask and direction are captured at acceptance, and `mem_addr` shows the captured address during the access.
- R2: Each access runs in this order: 2 bus-start cycles, setup, strobe, hold. The phase lengths come from the read or write timing inputs according to the access direction. A timing value of 0 counts as 1 cycle.
- R3: A read gives a one-cycle `rsp_valid` in cycle 2+setup+strobe+hold+1, counting the cycle after the accepting edge as cycle 1. `rsp_rdata` holds the bus value sampled in the final strobe cycle.
- R4: A write gives its one-cycle `rsp_valid` in its final hold cycle, which is cycle 2+setup+strobe+hold. There is no extra return cycle.
- R5: If read requests are kept waiting, N reads with timing 1/4/1 finish with the last `rsp_valid` in cycle 8*N+1 after the first accept.
- R6: `mem_oe_n` is low only in the strobe cycles of a read. `mem_we_n` is low only in the strobe cycles of a write.
- R7: `mem_dq_oe` is high exactly in the setup, strobe and hold cycles of a write. `mem_dq_o` carries the write data during that time. It is never high during a read.
- R8: With `cfg_sel_strobe`=0, `mem_cs_n` is low during setup, strobe and hold. With `cfg_sel_strobe`=1, it is low only during strobe.
- R9: Bit i of `req_be` enables byte lane i, which is data bits 8i+7:8i. Its pin `mem_be_n[i]` is active low during setup through hold and high at all other times. With `cfg_wide`=0, only lanes 0 and 1 are used: write lanes 2 and 3 are driven 0, `mem_be_n[3:2]` stays high, and read bits 31:16 return 0.
- R10: With `cfg_wait_en`=1, a high `mem_wait` in the final programmed strobe cycle adds one more strobe cycle. This repeats for as long as wait stays high, with no limit when `cfg_ext_wait`=0. Data is sampled in the strobe cycle where wait is seen low.
- R11: With `cfg_ext_wait`=1, wait can add at most T strobe cycles, where T=`cfg_timeout` and 0 counts as 1. If wait is still high after that, the strobe ends, the access finishes normally, and `rsp_err`=1 comes with its response. `rsp_err` is 0 on every other response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_setup | input | 4 | Read setup cycles (0 = 1) |
| cfg_rd_strobe | input | 4 | Read strobe cycles (0 = 1) |
| cfg_rd_hold | input | 4 | Read hold cycles (0 = 1) |
| cfg_wr_setup | input | 4 | Write setup cycles (0 = 1) |
| cfg_wr_strobe | input | 4 | Write strobe cycles (0 = 1) |
| cfg_wr_hold | input | 4 | Write hold cycles (0 = 1) |
| cfg_wide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| cfg_sel_strobe | input | 1 | Chip select active in strobe only |
| cfg_wait_en | input | 1 | Honour the wait pin |
| cfg_ext_wait | input | 1 | Limit wait with the timeout |
| cfg_timeout | input | 8 | Maximum wait-added strobe cycles (0 = 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i = lane i |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Wait timeout on this access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 4 | Byte lane enables, active low |
| mem_addr | output | 20 | Memory address |
| mem_dq_o | output | 32 | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 32 | Data from memory |
| mem_wait | input | 1 | Memory wait request |

## Verification
Every result has a known cycle relative to the accepting edge. A read response is due 2+setup+strobe+hold+1 cycles later, a write response 2+setup+strobe+hold cycles later, and each wait-added strobe cycle pushes both back by one. The bench counts cycles from acceptance and reads outputs at the falling edge. It records the first cycle with `rsp_valid`, counts the low cycles of every strobe and select pin, and compares those numbers with values worked out from the timing fields. In the back-to-back case, the last response is checked against cycle 8*N+1.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Fixed number of bus-start cycles in front of each access.
  localparam int START_CYCLES = 2;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_t;

endpackage

// File: rtl/asram_req_latch.sv
module asram_req_latch #(
  parameter int AW = 20,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           wr_in,
  input  logic [AW-1:0]  addr_in,
  input  logic [DW-1:0]  wdata_in,
  input  logic [BEW-1:0] be_in,
  output logic           wr_q,
  output logic [AW-1:0]  addr_q,
  output logic [DW-1:0]  wdata_q,
  output logic [BEW-1:0] be_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (capture) begin
      wr_q    <= wr_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
      be_q    <= be_in;
    end
  end

endmodule

// File: rtl/asram_wait_guard.sv
module asram_wait_guard #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,     // strobe phase is being entered
  input  logic            at_end,    // final programmed strobe cycle or later
  input  logic            wait_on,   // wait enabled and wait pin high
  input  logic            ext_en,
  input  logic [TO_W-1:0] limit,
  output logic            stretch,
  output logic            expire
);

  logic [TO_W-1:0] tcnt;
  logic [TO_W-1:0] lim_eff;

  assign lim_eff = (limit == '0) ? TO_W'(1) : limit;
  assign expire  = at_end && wait_on && ext_en && (tcnt == lim_eff);
  assign stretch = at_end && wait_on && !expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (clear) begin
      tcnt <= '0;
    end else if (stretch && (tcnt != '1)) begin
      tcnt <= tcnt + TO_W'(1);
    end
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq import asram_pkg::*; #(
  parameter int CNT_W = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             accept,
  input  logic             op_write,
  input  logic [CNT_W-1:0] rd_setup,
  input  logic [CNT_W-1:0] rd_strobe,
  input  logic [CNT_W-1:0] rd_hold,
  input  logic [CNT_W-1:0] wr_setup,
  input  logic [CNT_W-1:0] wr_strobe,
  input  logic [CNT_W-1:0] wr_hold,
  input  logic             stretch,
  input  logic             expire,
  output logic             at_end,
  output logic             strobe_entry,
  input  logic [DW-1:0]    rd_lane,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output phase_t           phase
);

  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             err_q;
  logic             rd_rsp_q;
  logic             rd_err_q;
  logic [DW-1:0]    rdata_q;
  logic             hold_last;
  logic             wr_done;
  logic [CNT_W-1:0] setup_m1, strobe_m1, hold_m1;

  function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign setup_m1  = len_m1(op_write ? wr_setup  : rd_setup);
  assign strobe_m1 = len_m1(op_write ? wr_strobe : rd_strobe);
  assign hold_m1   = len_m1(op_write ? wr_hold   : rd_hold);

  assign hold_last    = (phase == PH_HOLD) && (cnt == '0);
  assign req_ready    = (phase == PH_IDLE) || hold_last;
  assign accept       = req_valid && req_ready;
  assign at_end       = (phase == PH_STROBE) && (cnt == '0);
  assign strobe_entry = (phase == PH_SETUP) && (cnt == '0);
  assign wr_done      = hold_last && op_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_START;
            cnt   <= START_LAST;
          end
        end
        PH_START: begin
          if (cnt == '0) begin
            phase <= PH_SETUP;
            cnt   <= setup_m1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= strobe_m1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!stretch) begin
            phase <= PH_HOLD;
            cnt   <= hold_m1;
            err_q <= expire;
            if (!op_write) rdata_q <= rd_lane;
          end
        end
        PH_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (accept) begin
            phase <= PH_START;
            cnt   <= START_LAST;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // Read results leave one cycle after hold, overlapping a following access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rsp_q <= 1'b0;
      rd_err_q <= 1'b0;
    end else begin
      rd_rsp_q <= hold_last && !op_write;
      rd_err_q <= err_q;
    end
  end

  assign rsp_valid = rd_rsp_q || wr_done;
  assign rsp_err   = rd_rsp_q ? rd_err_q : (wr_done && err_q);
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/asram_pin_drv.sv
module asram_pin_drv import asram_pkg::*; #(
  parameter int DW = 32,
  localparam int BEW = DW / 8,
  localparam int NARROW_LANES = BEW / 2
) (
  input  phase_t         phase,
  input  logic           op_write,
  input  logic           sel_strobe,
  input  logic           wide,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  dq_in,
  output logic           cs_n,
  output logic           oe_n,
  output logic           we_n,
  output logic           dq_oe,
  output logic [BEW-1:0] be_n,
  output logic [DW-1:0]  dq_out,
  output logic [DW-1:0]  rd_lane
);

  logic in_access;
  logic in_strobe;

  assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe = (phase == PH_STROBE);

  assign cs_n  = sel_strobe ? !in_strobe : !in_access;
  assign oe_n  = !(in_strobe && !op_write);
  assign we_n  = !(in_strobe && op_write);
  assign dq_oe = in_access && op_write;

  for (genvar i = 0; i < BEW; i++) begin : g_lane
    logic lane_on;
    assign lane_on              = wide || (i < NARROW_LANES);
    assign be_n[i]              = !(in_access && be[i] && lane_on);
    assign dq_out[8*i +: 8]     = lane_on ? wdata[8*i +: 8] : 8'h00;
    assign rd_lane[8*i +: 8]    = lane_on ? dq_in[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl import asram_pkg::*; #(
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int CNT_W = 4,
  parameter int TO_W  = 8,
  localparam int BEW  = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_rd_setup,
  input  logic [CNT_W-1:0] cfg_rd_strobe,
  input  logic [CNT_W-1:0] cfg_rd_hold,
  input  logic [CNT_W-1:0] cfg_wr_setup,
  input  logic [CNT_W-1:0] cfg_wr_strobe,
  input  logic [CNT_W-1:0] cfg_wr_hold,
  input  logic             cfg_wide,
  input  logic             cfg_sel_strobe,
  input  logic             cfg_wait_en,
  input  logic             cfg_ext_wait,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [BEW-1:0]   req_be,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [BEW-1:0]   mem_be_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_i,
  input  logic             mem_wait
);

  logic           accept;
  logic           op_write;
  logic [DW-1:0]  op_wdata;
  logic [BEW-1:0] op_be;
  logic           stretch, expire, at_end, strobe_entry;
  logic [DW-1:0]  rd_lane;
  phase_t         phase;

  asram_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .wr_in    (req_write),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .be_in    (req_be),
    .wr_q     (op_write),
    .addr_q   (mem_addr),
    .wdata_q  (op_wdata),
    .be_q     (op_be)
  );

  asram_seq #(.CNT_W(CNT_W), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .accept       (accept),
    .op_write     (op_write),
    .rd_setup     (cfg_rd_setup),
    .rd_strobe    (cfg_rd_strobe),
    .rd_hold      (cfg_rd_hold),
    .wr_setup     (cfg_wr_setup),
    .wr_strobe    (cfg_wr_strobe),
    .wr_hold      (cfg_wr_hold),
    .stretch      (stretch),
    .expire       (expire),
    .at_end       (at_end),
    .strobe_entry (strobe_entry),
    .rd_lane      (rd_lane),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .phase        (phase)
  );

  asram_wait_guard #(.TO_W(TO_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (strobe_entry),
    .at_end  (at_end),
    .wait_on (cfg_wait_en && mem_wait),
    .ext_en  (cfg_ext_wait),
    .limit   (cfg_timeout),
    .stretch (stretch),
    .expire  (expire)
  );

  asram_pin_drv #(.DW(DW)) u_pins (
    .phase      (phase),
    .op_write   (op_write),
    .sel_strobe (cfg_sel_strobe),
    .wide       (cfg_wide),
    .be         (op_be),
    .wdata      (op_wdata),
    .dq_in      (mem_dq_i),
    .cs_n       (mem_cs_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe),
    .be_n       (mem_be_n),
    .dq_out     (mem_dq_o),
    .rd_lane    (rd_lane)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 20,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           cfg_wide,
  input logic           cfg_wait_en,
  input logic           cfg_ext_wait,
  input logic           mem_wait,
  input logic           mem_cs_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_dq_oe,
  input logic [BEW-1:0] mem_be_n,
  input logic [AW-1:0]  mem_addr,
  input logic           rsp_valid,
  input logic           rsp_err
);

  logic strobing;
  assign strobing = !mem_oe_n || !mem_we_n;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R1

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));  // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));  // R6

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);  // R7

  AST_CS_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strobing |-> !mem_cs_n);  // R8

  AST_NARROW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> (mem_be_n[BEW-1:BEW/2] == '1));  // R9

  AST_WAIT_KEEPS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && cfg_wait_en && !cfg_ext_wait && mem_wait) |=> strobing);  // R10

  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);  // R11

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cfg_wide     (cfg_wide),
  .cfg_wait_en  (cfg_wait_en),
  .cfg_ext_wait (cfg_ext_wait),
  .mem_wait     (mem_wait),
  .mem_cs_n     (mem_cs_n),
  .mem_oe_n     (mem_oe_n),
  .mem_we_n     (mem_we_n),
  .mem_dq_oe    (mem_dq_oe),
  .mem_be_n     (mem_be_n),
  .mem_addr     (mem_addr),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_rd_setup = 4'd1, cfg_rd_strobe = 4'd1, cfg_rd_hold = 4'd1;
  logic [3:0]  cfg_wr_setup = 4'd1, cfg_wr_strobe = 4'd1, cfg_wr_hold = 4'd1;
  logic        cfg_wide = 1'b1, cfg_sel_strobe = 1'b0, cfg_wait_en = 1'b0, cfg_ext_wait = 1'b0;
  logic [7:0]  cfg_timeout = 8'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = 4'hF;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [3:0]  mem_be_n;
  logic [19:0] mem_addr;
  logic [31:0] mem_dq_o;
  logic [31:0] mem_dq_i = '0;
  logic        mem_wait = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  asram_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_wide(cfg_wide), .cfg_sel_strobe(cfg_sel_strobe), .cfg_wait_en(cfg_wait_en),
    .cfg_ext_wait(cfg_ext_wait), .cfg_timeout(cfg_timeout),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  su, st, ho;
    logic        wide, sel, stuck;
    logic [7:0]  tmo;
    logic [3:0]  be;
    logic [31:0] wdata, mdata;
    logic [7:0]  e_lat;
    logic        e_err;
    logic [7:0]  e_stb, e_cs, e_drv;
    logic [31:0] e_dq;
    logic [3:0]  e_ben;
    logic [31:0] e_rd;
  } vec_t;

  localparam int NV = 7;
  // wr su st ho wide sel stuck tmo be wdata mdata | lat err stb cs drv dq ben rd
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd1, 4'd4, 4'd1, 1'b1, 1'b0, 1'b0, 8'd0, 4'hF, 32'h0, 32'h12345678,
      8'd9, 1'b0, 8'd4, 8'd6, 8'd0, 32'h0, 4'b0000, 32'h12345678},
    '{1'b1, 4'd1, 4'd1, 4'd1, 1'b1, 1'b0, 1'b0, 8'd0, 4'b0011, 32'hCAFEF00D, 32'h0,
      8'd5, 1'b0, 8'd1, 8'd3, 8'd3, 32'hCAFEF00D, 4'b1100, 32'h0},
    '{1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 8'd0, 4'hF, 32'h0, 32'hABCD1234,
      8'd6, 1'b0, 8'd1, 8'd1, 8'd0, 32'h0, 4'b1100, 32'h00001234},
    '{1'b1, 4'd2, 4'd3, 4'd2, 1'b1, 1'b1, 1'b0, 8'd0, 4'hF, 32'h0BADC0DE, 32'h0,
      8'd9, 1'b0, 8'd3, 8'd3, 8'd7, 32'h0BADC0DE, 4'b0000, 32'h0},
    '{1'b0, 4'd1, 4'd2, 4'd1, 1'b1, 1'b0, 1'b1, 8'd3, 4'hF, 32'h0, 32'h55AA55AA,
      8'd10, 1'b1, 8'd5, 8'd7, 8'd0, 32'h0, 4'b0000, 32'h55AA55AA},
    '{1'b1, 4'd1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b1, 8'd2, 4'hF, 32'hDEADBEEF, 32'h0,
      8'd7, 1'b1, 8'd3, 8'd5, 8'd5, 32'h0000BEEF, 4'b1100, 32'h0},
    '{1'b0, 4'd3, 4'd1, 4'd2, 1'b1, 1'b0, 1'b0, 8'd0, 4'b1010, 32'h0, 32'h0F0F0F0F,
      8'd9, 1'b0, 8'd1, 8'd6, 8'd0, 32'h0, 4'b0101, 32'h0F0F0F0F}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_timing(input logic [3:0] su, input logic [3:0] st, input logic [3:0] ho);
    cfg_rd_setup = su; cfg_rd_strobe = st; cfg_rd_hold = ho;
    cfg_wr_setup = su; cfg_wr_strobe = st; cfg_wr_hold = ho;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int k, lat, stb, cs, drv;
    logic [31:0] dq_seen, rd_seen;
    logic [19:0] addr_seen, addr_exp;
    logic [3:0]  ben_seen;
    logic        err_seen;
    bit          got;
    k = 1; lat = 0; stb = 0; cs = 0; drv = 0; got = 1'b0;
    dq_seen = '0; rd_seen = '0; ben_seen = '0; err_seen = 1'b0; addr_seen = '0;
    addr_exp = 20'h40000 | 20'(idx * 4);
    @(negedge clk);
    set_timing(v.su, v.st, v.ho);
    cfg_wide = v.wide; cfg_sel_strobe = v.sel;
    cfg_wait_en = v.stuck; cfg_ext_wait = v.stuck; mem_wait = v.stuck; cfg_timeout = v.tmo;
    mem_dq_i = v.mdata;
    req_write = v.wr; req_addr = addr_exp; req_wdata = v.wdata; req_be = v.be;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && k < 200) begin
      if (!mem_oe_n || !mem_we_n) begin
        if (stb == 0) begin
          ben_seen = mem_be_n; dq_seen = mem_dq_o; addr_seen = mem_addr;
        end
        stb++;
      end
      if (!mem_cs_n) cs++;
      if (mem_dq_oe) drv++;
      if (rsp_valid) begin
        got = 1'b1; lat = k; err_seen = rsp_err; rd_seen = rsp_rdata;
      end else begin
        @(negedge clk);
        k++;
      end
    end
    chk(v.wr ? "R4" : "R3", "latency", 32'(lat), 32'(v.e_lat));
    chk("R11", "rsp_err", 32'(err_seen), 32'(v.e_err));
    chk(v.stuck ? "R11" : "R6", "strobe cycles", 32'(stb), 32'(v.e_stb));
    chk("R8", "cs cycles", 32'(cs), 32'(v.e_cs));
    chk("R7", "drive cycles", 32'(drv), 32'(v.e_drv));
    chk("R9", "byte lanes", 32'(ben_seen), 32'(v.e_ben));
    chk("R1", "address", 32'(addr_seen), 32'(addr_exp));
    if (v.wr) chk("R7", "write data", dq_seen, v.e_dq);
    else      chk("R3", "read data", rd_seen, v.e_rd);
    mem_wait = 1'b0; cfg_wait_en = 1'b0; cfg_ext_wait = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int k, acc, nrsp, first, last;
    bit drop;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R6", "oe_n at reset", 32'(mem_oe_n), 32'd1);
    chk("R6", "we_n at reset", 32'(mem_we_n), 32'd1);
    chk("R8", "cs_n at reset", 32'(mem_cs_n), 32'd1);
    chk("R7", "dq_oe at reset", 32'(mem_dq_oe), 32'd0);
    chk("R9", "be_n at reset", 32'(mem_be_n), 32'hF);
    chk("R3", "rsp_valid at reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready when idle", 32'(req_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R5: three queued reads at 1/4/1
    set_timing(4'd1, 4'd4, 4'd1);
    cfg_wide = 1'b1; cfg_sel_strobe = 1'b0; mem_dq_i = 32'h00C0FFEE;
    req_write = 1'b0; req_be = 4'hF;
    req_valid = 1'b1;
    k = 0; acc = 0; nrsp = 0; first = 0; last = 0; drop = 1'b0;
    while (nrsp < 3 && k < 200) begin
      if (req_valid && req_ready) begin
        acc++;
        if (acc == 3) drop = 1'b1;
      end
      @(negedge clk);
      k++;
      if (drop) begin req_valid = 1'b0; drop = 1'b0; end
      if (rsp_valid) begin
        nrsp++;
        if (nrsp == 1) first = k;
        last = k;
      end
    end
    chk("R5", "first of queued reads", 32'(first), 32'd9);
    chk("R5", "last of three queued reads", 32'(last), 32'd25);
    chk("R5", "responses counted", 32'(nrsp), 32'd3);
    repeat (2) @(negedge clk);

    // R10: wait stretch without timeout, data sampled after wait drops
    set_timing(4'd1, 4'd1, 4'd1);
    cfg_wait_en = 1'b1; cfg_ext_wait = 1'b0; mem_wait = 1'b1; mem_dq_i = 32'h11111111;
    req_write = 1'b0; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int stb, lat;
      bit got;
      logic err_seen;
      logic [31:0] rd_seen;
      k = 1; stb = 0; lat = 0; got = 1'b0; err_seen = 1'b0; rd_seen = '0;
      while (!got && k < 200) begin
        if (k == 2) chk("R1", "ready low mid-access", 32'(req_ready), 32'd0);
        if (k == 8) begin mem_wait = 1'b0; mem_dq_i = 32'h22222222; end
        if (!mem_oe_n) stb++;
        if (rsp_valid) begin
          got = 1'b1; lat = k; err_seen = rsp_err; rd_seen = rsp_rdata;
        end else begin
          @(negedge clk);
          k++;
        end
      end
      chk("R10", "stretched strobe", 32'(stb), 32'd5);
      chk("R10", "stretched latency", 32'(lat), 32'd10);
      chk("R10", "data after wait", rd_seen, 32'h22222222);
      chk("R10", "no error without timeout", 32'(err_seen), 32'd0);
    end
    cfg_wait_en = 1'b0;
    @(negedge clk);

    // R11: timeout value 0 acts as 1
    begin
      vec_t z;
      z = '{1'b0, 4'd1, 4'd1, 4'd1, 1'b1, 1'b0, 1'b1, 8'd0, 4'hF, 32'h0, 32'h76543210,
            8'd7, 1'b1, 8'd2, 8'd4, 8'd0, 32'h0, 4'b0000, 32'h76543210};
      run_vec(z, 9);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule